// File: doc/BRIEF.md
# MSI capability register file

This block holds the message-signalled-interrupt capability structure that sits inside a PCI function's configuration space. Configuration writes arrive as a dword index relative to the capability base, four byte enables and 32 bits of data. Reads return the addressed dword combinationally. The block keeps the enable and multiple-message-enable controls, the message address and data, and a per-vector mask register. It also keeps a pending register that only the message dispatcher may change, through set and clear strobes.

The layout is fixed at build time, either with 64-bit addressing or with 32-bit addressing. Each configuration write is applied byte lane by byte lane. Read-only fields keep their reset values whatever is written to them. A write to the mask register can clear a mask bit whose vector is pending while the capability is enabled. For each such vector the block raises a one-cycle replay request, so that the dispatcher can send the message that was held back. The dispatcher reads the message address, data and enable from dedicated outputs.

Top module: `msi_cap_regs`

## Requirements
- R1: Dword 0 byte 0 reads the capability ID 0x05 and byte 1 reads the NEXT_PTR parameter; writes to both bytes are ignored.
- R2: In message control bits 7:0 (dword 0 byte 2), only bit 0 (enable) and bits 6:4 (multiple message enable) take written values. Bits 3:1 read the multiple-message-capable code. Bit 7 reads 1 only in the 64-bit layout.
- R3: Message control bits 15:8 (dword 0 byte 3) read 0x01, the per-vector-masking capable flag, and ignore writes.
- R4: After reset, enable, multiple message enable, mask and pending are zero. The capable code is the smallest n with 2^n >= NUM_VEC; for the defaults (NUM_VEC=8, 64-bit, NEXT_PTR=0x70), dword 0 reads 0x01867005.
- R5: Each byte lane of a write is applied only when its byte enable is set; a lane that is not enabled leaves its byte unchanged.
- R6: Dword map in the 64-bit layout: 1 address low, 2 address high, 3 data (bits 15:0, upper half reads 0), 4 mask, 5 pending. In the 32-bit layout: 1 address low, 2 data, 3 mask, 4 pending. Any other dword reads 0.
- R7: Mask bit b of mask byte k governs vector 8k+b. While enabled, a write that clears a mask bit from 1 to 0 with that vector pending sets replayReq bit 8k+b for exactly the one cycle after the write edge.
- R8: No replay is raised for a 0-to-1 mask change, for a vector that is not pending, or while the capability is disabled.
- R9: Configuration writes to the pending register are ignored. pendSet sets bits and pendClr clears them on the next edge, with set winning when both are given. Bits for vectors at or above NUM_VEC stay 0.
- R10: msiEnable, multiMsgEn, msgAddr and msgData follow the stored fields; in the 32-bit layout msgAddr[63:32] is 0.
- R11: A NUM_VEC outside 1 to 32 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Dword index relative to the capability base |
| cfgByteEn | input | 4 | Byte lane enables for the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for cfgAddr |
| pendSet | input | 32 | Dispatcher: set pending bits |
| pendClr | input | 32 | Dispatcher: clear pending bits |
| replayReq | output | 32 | One-cycle request per vector to resend a held-back message |
| msiEnable | output | 1 | Capability enable |
| multiMsgEn | output | 3 | Multiple message enable field |
| msgAddr | output | 64 | Message address |
| msgData | output | 16 | Message data |

## Verification
On every cycle, the assertions check that a replay bit appears only for a vector that was pending while the capability was enabled. They also check that pending bits follow the set and clear strobes, and that mask and control contents hold when no write targets them. Other behaviour can only be shown by the bench's scenarios. This covers the effect of byte enables on each lane, the read-only header and capable fields, the two layouts with their dword maps, and the vector-to-mask-bit mapping. It also covers the absence of replay on 0-to-1 changes and while disabled.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int ADDR_W = 3;
  localparam int VEC_MAX = 32;
  localparam logic [7:0] CAP_ID = 8'h05;

  typedef enum logic [2:0] {
    SEL_HDR, SEL_ALO, SEL_AHI, SEL_DATA, SEL_MASK, SEL_PEND, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic       ctrlWr;
    logic       addrLoWr;
    logic       addrHiWr;
    logic       dataWr;
    logic       maskWr;
    logic [3:0] be;
  } wrStrb_t;

  function automatic logic [2:0] capCode(input int count);
    for (int n = 0; n < 6; n++)
      if ((1 << n) >= count) return n[2:0];
    return 3'd5;
  endfunction
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit IS64 = 1'b1
) (
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  output rdSel_e            rdSel,
  output wrStrb_t           strb
);
  generate
    if (IS64) begin : gLayout64
      always_comb begin
        case (cfgAddr)
          3'd0: rdSel = SEL_HDR;
          3'd1: rdSel = SEL_ALO;
          3'd2: rdSel = SEL_AHI;
          3'd3: rdSel = SEL_DATA;
          3'd4: rdSel = SEL_MASK;
          3'd5: rdSel = SEL_PEND;
          default: rdSel = SEL_NONE;
        endcase
      end
    end else begin : gLayout32
      always_comb begin
        case (cfgAddr)
          3'd0: rdSel = SEL_HDR;
          3'd1: rdSel = SEL_ALO;
          3'd2: rdSel = SEL_DATA;
          3'd3: rdSel = SEL_MASK;
          3'd4: rdSel = SEL_PEND;
          default: rdSel = SEL_NONE;
        endcase
      end
    end
  endgenerate

  always_comb begin
    strb.be       = cfgByteEn;
    strb.ctrlWr   = cfgWrEn && rdSel == SEL_HDR && cfgByteEn[2];
    strb.addrLoWr = cfgWrEn && rdSel == SEL_ALO;
    strb.addrHiWr = cfgWrEn && rdSel == SEL_AHI;
    strb.dataWr   = cfgWrEn && rdSel == SEL_DATA;
    strb.maskWr   = cfgWrEn && rdSel == SEL_MASK;
  end
endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
#(
  parameter bit       IS64     = 1'b1,
  parameter int       NUM_VEC  = 8,
  parameter bit [7:0] NEXT_PTR = 8'h70
) (
  input  logic               clk,
  input  logic               rst,
  input  rdSel_e             rdSel,
  input  wrStrb_t            strb,
  input  logic [31:0]        wrData,
  input  logic [VEC_MAX-1:0] pendSet,
  input  logic [VEC_MAX-1:0] pendClr,
  output logic [31:0]        rdData,
  output logic [VEC_MAX-1:0] replayReq,
  output logic               enOut,
  output logic [2:0]         mmeOut,
  output logic [63:0]        addrOut,
  output logic [15:0]        dataOut
);
  localparam logic [2:0] MMC = capCode(NUM_VEC);
  localparam logic [VEC_MAX-1:0] VALID =
    (NUM_VEC >= VEC_MAX) ? {VEC_MAX{1'b1}} : VEC_MAX'((64'd1 << NUM_VEC) - 64'd1);

  logic               enReg;
  logic [2:0]         mmeReg;
  logic [31:0]        addrLoReg, addrHiReg, addrLoNext, addrHiNext;
  logic [15:0]        dataReg, dataNext;
  logic [VEC_MAX-1:0] maskReg, maskNext, pendReg, replayNext;

  function automatic logic [31:0] laneMerge(input logic [31:0] cur, input logic [31:0] nw,
                                            input logic [3:0] be);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  always_comb begin
    addrLoNext = strb.addrLoWr ? laneMerge(addrLoReg, wrData, strb.be) : addrLoReg;
    addrHiNext = strb.addrHiWr ? laneMerge(addrHiReg, wrData, strb.be) : addrHiReg;
    dataNext   = strb.dataWr ? laneMerge({16'h0, dataReg}, wrData, {2'b00, strb.be[1:0]}) >> 0
                             : {16'h0, dataReg};
    maskNext   = strb.maskWr ? laneMerge(maskReg, wrData, strb.be) : maskReg;
    replayNext = (strb.maskWr && enReg) ? (maskReg & ~maskNext & pendReg) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg     <= 1'b0;
      mmeReg    <= 3'd0;
      addrLoReg <= '0;
      addrHiReg <= '0;
      dataReg   <= '0;
      maskReg   <= '0;
      pendReg   <= '0;
      replayReq <= '0;
    end else begin
      if (strb.ctrlWr) begin
        enReg  <= wrData[16];
        mmeReg <= wrData[22:20];
      end
      addrLoReg <= addrLoNext;
      addrHiReg <= addrHiNext;
      dataReg   <= dataNext;
      maskReg   <= maskNext;
      pendReg   <= ((pendReg & ~pendClr) | pendSet) & VALID;
      replayReq <= replayNext;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_HDR:  rdData = {8'h01, IS64, mmeReg, MMC, enReg, NEXT_PTR, CAP_ID};
      SEL_ALO:  rdData = addrLoReg;
      SEL_AHI:  rdData = addrHiReg;
      SEL_DATA: rdData = {16'h0, dataReg};
      SEL_MASK: rdData = maskReg;
      SEL_PEND: rdData = pendReg;
      default:  rdData = '0;
    endcase
  end

  assign enOut   = enReg;
  assign mmeOut  = mmeReg;
  assign addrOut = IS64 ? {addrHiReg, addrLoReg} : {32'h0, addrLoReg};
  assign dataOut = dataReg;

  assert_replay_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (replayReq != '0) |-> ((replayReq & ~$past(pendReg)) == '0));
  assert_replay_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    (replayReq != '0) |-> $past(enReg));
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (rst)
    ((pendSet & VALID) != '0) |=> ((pendReg & $past(pendSet & VALID)) == $past(pendSet & VALID)));
  assert_pend_clr_R9: assert property (@(posedge clk) disable iff (rst)
    ((pendClr & ~pendSet) != '0) |=> ((pendReg & $past(pendClr & ~pendSet)) == '0));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strb.maskWr |=> $stable(maskReg));
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.ctrlWr |=> $stable({enReg, mmeReg}));
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit       IS64     = 1'b1,
  parameter int       NUM_VEC  = 8,
  parameter bit [7:0] NEXT_PTR = 8'h70
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [3:0]          cfgByteEn,
  input  logic [31:0]         cfgWrData,
  output logic [31:0]         cfgRdData,
  input  logic [VEC_MAX-1:0]  pendSet,
  input  logic [VEC_MAX-1:0]  pendClr,
  output logic [VEC_MAX-1:0]  replayReq,
  output logic                msiEnable,
  output logic [2:0]          multiMsgEn,
  output logic [63:0]         msgAddr,
  output logic [15:0]         msgData
);
  generate
    if (NUM_VEC < 1 || NUM_VEC > VEC_MAX) begin : gBadVecCount_R11
      $error("msi_cap_regs: NUM_VEC must be 1..32");
    end
  endgenerate

  rdSel_e  rdSel;
  wrStrb_t strb;

  msi_cap_ctrl #(.IS64(IS64)) uCtrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgByteEn(cfgByteEn),
    .rdSel    (rdSel),
    .strb     (strb)
  );

  msi_cap_dp #(.IS64(IS64), .NUM_VEC(NUM_VEC), .NEXT_PTR(NEXT_PTR)) uDp (
    .clk      (clk),
    .rst      (rst),
    .rdSel    (rdSel),
    .strb     (strb),
    .wrData   (cfgWrData),
    .pendSet  (pendSet),
    .pendClr  (pendClr),
    .rdData   (cfgRdData),
    .replayReq(replayReq),
    .enOut    (msiEnable),
    .mmeOut   (multiMsgEn),
    .addrOut  (msgAddr),
    .dataOut  (msgData)
  );
endmodule

// File: tb/tb_msi_cap_regs.sv
module tb_msi_cap_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0, pendSet = '0, pendClr = '0;
  logic [31:0] rdData, rdData32, replayReq, replay32;
  logic msiEnable, en32;
  logic [2:0] multiMsgEn, mme32;
  logic [63:0] msgAddr, addr32;
  logic [15:0] msgData, data32;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cap_regs dut (.clk, .rst, .cfgWrEn, .cfgAddr, .cfgByteEn, .cfgWrData,
    .cfgRdData(rdData), .pendSet, .pendClr, .replayReq, .msiEnable, .multiMsgEn,
    .msgAddr, .msgData);

  msi_cap_regs #(.IS64(1'b0), .NUM_VEC(2), .NEXT_PTR(8'h00)) dut32 (.clk, .rst, .cfgWrEn,
    .cfgAddr, .cfgByteEn, .cfgWrData, .cfgRdData(rdData32), .pendSet, .pendClr,
    .replayReq(replay32), .msiEnable(en32), .multiMsgEn(mme32), .msgAddr(addr32),
    .msgData(data32));

  // behavioural reference for the 64-bit default instance
  bit mEn; bit [2:0] mMme; bit [31:0] mLo, mHi, mMask, mPend, mRep; bit [15:0] mData;

  function automatic bit [31:0] mRead(input int a);
    case (a)
      0: return {8'h01, 1'b1, mMme, 3'd3, mEn, 8'h70, 8'h05};
      1: return mLo;
      2: return mHi;
      3: return {16'h0, mData};
      4: return mMask;
      5: return mPend;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mEn = 0; mMme = 0; mLo = 0; mHi = 0; mData = 0; mMask = 0; mPend = 0; mRep = 0;
    end else begin
      mRep = 0;
      if (cfgWrEn) begin
        for (int i = 0; i < 32; i++) begin
          if (cfgByteEn[i/8]) begin
            case (cfgAddr)
              3'd0: if (i == 16) mEn = cfgWrData[16];
                    else if (i >= 20 && i <= 22) mMme[i-20] = cfgWrData[i];
              3'd1: mLo[i] = cfgWrData[i];
              3'd2: mHi[i] = cfgWrData[i];
              3'd3: if (i < 16) mData[i] = cfgWrData[i];
              3'd4: begin
                if (mEn && mMask[i] && !cfgWrData[i] && mPend[i]) mRep[i] = 1;
                mMask[i] = cfgWrData[i];
              end
              default: ;
            endcase
          end
        end
      end
      mPend = ((mPend & ~pendClr) | pendSet) & 32'hFF;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R6 readback vs model", 64'(rdData), 64'(mRead(int'(cfgAddr))));
    chk("R7 replay vs model", 64'(replayReq), 64'(mRep));
    chk("R10 enable vs model", 64'(msiEnable), 64'(mEn));
    chk("R10 address vs model", msgAddr, {mHi, mLo});
    chk("R10 data vs model", 64'(msgData), 64'(mData));
  end

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    cfgAddr = 3'(a); cfgByteEn = be; cfgWrData = d; cfgWrEn = 1;
    @(posedge clk); #1;
    cfgWrEn = 0;
  endtask

  task automatic pend(input logic [31:0] s, input logic [31:0] c);
    pendSet = s; pendClr = c;
    @(posedge clk); #1;
    pendSet = 0; pendClr = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    cfgAddr = 3'(a);
    @(negedge clk);
    chk(tag, 64'(rdData), 64'(exp));
    @(posedge clk); #1;
  endtask

  task automatic rd32(input int a, input logic [31:0] exp, input string tag);
    cfgAddr = 3'(a);
    @(negedge clk);
    chk(tag, 64'(rdData32), 64'(exp));
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    rd(0, 32'h01867005, "R4 header and control after reset");
    rd(4, 32'h0, "R4 mask after reset");
    rd(5, 32'h0, "R4 pending after reset");
    chk("R4 enable after reset", 64'(msiEnable), 64'd0);

    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd(0, 32'h01F77005, "R1 R2 R3 control write keeps read-only fields");
    chk("R10 multiMsgEn", 64'(multiMsgEn), 64'd7);
    wr(0, 4'b1011, 32'h0);
    rd(0, 32'h01F77005, "R5 lane 2 disabled keeps control");
    wr(0, 4'b0100, 32'h0);
    rd(0, 32'h01867005, "R2 control cleared");

    wr(1, 4'b0101, 32'hAABBCCDD);
    rd(1, 32'h00BB00DD, "R5 address low lanes 0 and 2");
    wr(2, 4'hF, 32'h12345678);
    chk("R10 msgAddr", msgAddr, 64'h12345678_00BB00DD);
    wr(3, 4'hF, 32'hFFFF1234);
    rd(3, 32'h00001234, "R6 data upper half reads zero");
    rd(6, 32'h0, "R6 unmapped dword");
    rd(7, 32'h0, "R6 unmapped dword");

    wr(5, 4'hF, 32'hFFFF_FFFF);
    rd(5, 32'h0, "R9 pending ignores config write");
    pend(32'hFFFF_FFFF, 32'h0);
    rd(5, 32'h000000FF, "R9 pending only for valid vectors");
    pend(32'h1, 32'h0F);
    rd(5, 32'h000000F1, "R9 clear with set winning");

    wr(0, 4'b0100, 32'h0001_0000);
    wr(4, 4'h1, 32'hFF);
    chk("R8 no replay on 0-to-1", 64'(replayReq), 64'd0);
    wr(4, 4'h1, 32'h00);
    chk("R7 replay pending unmasked vectors", 64'(replayReq), 64'hF1);
    @(posedge clk); #1;
    chk("R7 replay lasts one cycle", 64'(replayReq), 64'd0);

    wr(4, 4'h1, 32'h05);
    pend(32'h0, 32'hFF);
    pend(32'h5, 32'h0);
    wr(4, 4'h1, 32'h01);
    chk("R7 vector 2 only", 64'(replayReq), 64'h4);
    wr(4, 4'hF, 32'h0000_FF01);
    wr(4, 4'b0010, 32'h0);
    chk("R8 not pending gives no replay", 64'(replayReq), 64'd0);

    wr(4, 4'h1, 32'hFF);
    wr(0, 4'b0100, 32'h0);
    wr(4, 4'h1, 32'h00);
    chk("R8 disabled gives no replay", 64'(replayReq), 64'd0);

    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    rd32(0, 32'h01020005, "R4 R6 32-bit header");
    wr(3, 4'h1, 32'h3);
    rd32(3, 32'h3, "R6 32-bit mask dword");
    wr(0, 4'b0100, 32'h0001_0000);
    pend(32'h2, 32'h0);
    rd32(4, 32'h2, "R6 32-bit pending dword");
    wr(3, 4'h1, 32'h1);
    chk("R7 32-bit replay", 64'(replay32), 64'h2);
    wr(1, 4'hF, 32'hCAFE0000);
    chk("R10 32-bit msgAddr upper zero", addr32, 64'hCAFE0000);
    rd32(5, 32'h0, "R6 32-bit unmapped");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule